// File: doc/BRIEF.md
# Entropy Sampling Collector

This block collects a burst of raw random bits from a single-bit entropy source, typically a free-running ring oscillator that enters the chip as an ordinary signal. The source first passes through a two-flop synchronizer. Software programs three things through a small register port: the number of clock cycles between captures, the oscillator speed it wants, and how many bits it needs. It then raises a start flag. The block captures one synchronized bit per period and packs the bits into a private buffer. When the requested number of bits is in, it copies the filled words to the readable result registers and drops the start flag. Software polls that flag to learn that the data is ready.

The control register is written through a per-bit mask. The upper half of the written word selects which bits of the lower half take effect. This lets software raise start, or change one field, without a read-modify-write. The speed field drives the `osc_speed` port towards the oscillator. If collection stops without finishing, the half-filled buffer is dropped, so the result registers never hold a mixture of old and new bits.

Top module: `entropy_collector`

## Requirements
- R1: After reset every register reads 0 and `osc_speed` is 0.
- R2: A write to the control register at offset 0x400 changes control bit n (n = 0..5) only when write-data bit n+16 is set. Bits whose mask bit is clear keep their value.
- R3: The control register reads back as {len[5:4], speed[3:2], enable[1], start[0]}, with all other bits 0. `osc_speed` always equals the speed field.
- R4: A len field of 0, 1, 2 or 3 requests 64, 128, 192 or 256 bits. A finished collection updates result words 0..(2·len+1). Higher words keep their earlier contents.
- R5: Result word i reads at offset 0x410 + 4·i. The first captured bit lands in bit 31 of word 0. Later bits fill each word downwards towards bit 0, then continue in the next word.
- R6: Start stays 1 while a collection runs. The hardware clears start at completion, and the new result words are readable from the cycle in which start reads 0.
- R7: The register at 0x404 sets the capture period in clock cycles. A collection of N bits takes at least N·max(period,1) cycles. A period of 0 captures one bit per cycle.
- R8: When enable is 0, start is cleared and no collection runs. Clearing enable during a collection aborts it, and the result words stay unchanged.
- R9: Writing 0xFFFF0000 to the control register clears all control fields, so start, enable, speed and `osc_speed` read 0.
- R10: Reads at offsets other than 0x400, 0x404 and 0x410..0x42C return 0. Writes to the result words have no effect.
- R11: The sample period register at 0x404 reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_rd | input | 1 | Read strobe; data appears on `reg_rdata` one cycle later |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data; for the control register, bits 31:16 are the bit mask |
| reg_rdata | output | 32 | Registered read data |
| entropy_in | input | 1 | Asynchronous raw entropy bit |
| osc_speed | output | 2 | Oscillator speed selection from the control register |

## Verification
The source is driven with a known bit pattern that holds each value for a full four-cycle capture window. Any error in bit order, word order or sampling phase therefore shows up as wrong data words. A full 256-bit run sets every result word. Shorter 64- and 192-bit runs follow it, and separate the words a run must refresh from the words it must leave alone. A constant-one source with a period of 0 shows one capture per cycle. Completion times measured against the start write show that the period setting is obeyed. A collection aborted halfway, and a start raised without enable, must both leave the result words exactly as they were.

// File: rtl/entcol_pkg.sv
package entcol_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_WORDS = 8;
  localparam int CTL_W     = 6;
  localparam int MASK_LSB  = 16;

  localparam int OFS_CTL    = 'h400;
  localparam int OFS_PERIOD = 'h404;
  localparam int OFS_DATA0  = 'h410;

  // start is bit 0, enable bit 1, speed bits 3:2, length bits 5:4
  typedef struct packed {
    logic [1:0] len;
    logic [1:0] speed;
    logic       enable;
    logic       start;
  } ctl_t;
endpackage

// File: rtl/entcol_sync.sv
module entcol_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/entcol_timer.sv
module entcol_timer #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [IDX_W-1:0] nbits,
  output logic             cap,
  output logic [IDX_W-1:0] cap_idx,
  output logic             filled
);
  logic [CNT_W-1:0] cyc_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] last;

  // a period of zero behaves as one cycle
  assign last    = (period == '0) ? '0 : period - 1'b1;
  assign filled  = run && (idx_q >= nbits);
  assign cap     = run && !filled && (cyc_q >= last);
  assign cap_idx = idx_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cyc_q <= '0;
      idx_q <= '0;
    end else if (cap) begin
      cyc_q <= '0;
      idx_q <= idx_q + 1'b1;
    end else if (!filled) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/entcol_packer.sv
module entcol_packer #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 8,
  parameter int IDX_W  = 9,
  parameter int NW_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap,
  input  logic [IDX_W-1:0]         cap_idx,
  input  logic                     bit_in,
  input  logic                     commit,
  input  logic [NW_W-1:0]          nwords_used,
  output logic [NWORDS*WORD_W-1:0] words
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int SEL_W = IDX_W - BIT_W;

  logic [BIT_W-1:0] bitpos;
  assign bitpos = BIT_W'(WORD_W - 1) - cap_idx[BIT_W-1:0];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] shadow_q;
    logic [WORD_W-1:0] held_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
        held_q   <= '0;
      end else begin
        if (cap && cap_idx[IDX_W-1:BIT_W] == SEL_W'(w))
          shadow_q[bitpos] <= bit_in;
        if (commit && nwords_used > NW_W'(w))
          held_q <= shadow_q;
      end
    end

    assign words[w*WORD_W +: WORD_W] = held_q;
  end
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
  import entcol_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              entropy_in,
  output logic [1:0]        osc_speed
);
  localparam int MAX_BITS = MAX_WORDS * WORD_W;
  localparam int LEN_STEP = MAX_BITS / 4;
  localparam int IDX_W    = $clog2(MAX_BITS + 1);
  localparam int NW_W     = $clog2(MAX_WORDS + 1);
  localparam int SEL_W    = $clog2(MAX_WORDS);
  localparam int SPAN     = MAX_WORDS * 4;

  ctl_t                      ctl_q, ctl_next;
  logic [CNT_W-1:0]          period_q;
  logic [31:0]               rdata_q, rd_mux;
  logic                      wr_ctl, wr_period, run, cap, filled, bit_sync;
  logic [IDX_W-1:0]          cap_idx, nbits;
  logic [NW_W-1:0]           nwords;
  logic [MAX_WORDS*WORD_W-1:0] data_words;
  logic [CTL_W-1:0]          cur, wmask, wval;
  logic [ADDR_W-1:0]         doff;
  logic                      in_data;
  logic                      start_bit, enable_bit;
  logic                      unused_wdata;

  assign unused_wdata = ^{reg_wdata[31:MASK_LSB+CTL_W], reg_wdata[MASK_LSB-1:CTL_W]};

  assign wr_ctl    = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
  assign wr_period = reg_wr && (reg_addr == ADDR_W'(OFS_PERIOD));

  assign cur   = ctl_q;
  assign wmask = reg_wdata[MASK_LSB +: CTL_W];
  assign wval  = reg_wdata[CTL_W-1:0];

  always_comb begin
    ctl_next = ctl_q;
    if (wr_ctl)
      ctl_next = ctl_t'((cur & ~wmask) | (wval & wmask));
    else if (ctl_q.start && (!ctl_q.enable || filled))
      ctl_next.start = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      period_q <= '0;
    end else begin
      ctl_q <= ctl_next;
      if (wr_period) period_q <= reg_wdata[CNT_W-1:0];
    end
  end

  assign run        = ctl_q.start && ctl_q.enable;
  assign nbits      = IDX_W'((int'(ctl_q.len) + 1) * LEN_STEP);
  assign nwords     = NW_W'((int'(ctl_q.len) + 1) * (MAX_WORDS / 4));
  assign osc_speed  = ctl_q.speed;
  assign start_bit  = ctl_q.start;
  assign enable_bit = ctl_q.enable;

  entcol_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (entropy_in),
    .q   (bit_sync)
  );

  entcol_timer #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .period  (period_q),
    .nbits   (nbits),
    .cap     (cap),
    .cap_idx (cap_idx),
    .filled  (filled)
  );

  entcol_packer #(.WORD_W(WORD_W), .NWORDS(MAX_WORDS), .IDX_W(IDX_W), .NW_W(NW_W)) u_pack (
    .clk         (clk),
    .rst         (rst),
    .cap         (cap),
    .cap_idx     (cap_idx),
    .bit_in      (bit_sync),
    .commit      (filled),
    .nwords_used (nwords),
    .words       (data_words)
  );

  assign doff    = reg_addr - ADDR_W'(OFS_DATA0);
  assign in_data = (reg_addr >= ADDR_W'(OFS_DATA0)) && (doff < ADDR_W'(SPAN))
                   && (doff[1:0] == 2'b00);

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFS_CTL))
      rd_mux = 32'(cur);
    else if (reg_addr == ADDR_W'(OFS_PERIOD))
      rd_mux = 32'(period_q);
    else if (in_data)
      rd_mux = data_words[int'(doff[SEL_W+1:2])*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/entcol_checker.sv
module entcol_checker #(
  parameter int ADDR_W = 12,
  parameter int DW     = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [1:0]        osc_speed,
  input logic              start_bit,
  input logic              enable_bit,
  input logic [DW-1:0]     data_words
);
  logic ctl_w, undef_rd;
  assign ctl_w    = reg_wr && (reg_addr == ADDR_W'('h400));
  assign undef_rd = reg_rd && (reg_addr != ADDR_W'('h400)) && (reg_addr != ADDR_W'('h404))
                    && !((reg_addr >= ADDR_W'('h410)) && (reg_addr < ADDR_W'('h430))
                         && (reg_addr[1:0] == 2'b00));

  AST_MASK_KEEPS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && !reg_wdata[17]) |=> $stable(enable_bit)); // R2

  AST_SPEED_TO_PORT: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata[19:18] == 2'b11) |=> (osc_speed == $past(reg_wdata[3:2]))); // R3

  AST_NO_START_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (start_bit && !enable_bit && !ctl_w) |=> !start_bit); // R8

  AST_RESULTS_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !start_bit |=> $stable(data_words)); // R8

  AST_STOP_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && reg_wdata == 32'hFFFF_0000) |=> (!start_bit && !enable_bit && osc_speed == 2'b00)); // R9

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    undef_rd |=> (reg_rdata == 32'h0)); // R10
endmodule

bind entropy_collector entcol_checker #(.ADDR_W(ADDR_W), .DW(entcol_pkg::MAX_WORDS*entcol_pkg::WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .osc_speed  (osc_speed),
  .start_bit  (start_bit),
  .enable_bit (enable_bit),
  .data_words (data_words)
);

// File: tb/entropy_collector_tb.sv
module entropy_collector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_CTL = 12'h400, A_PER = 12'h404, A_D0 = 12'h410;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0, entropy_in = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0] osc_speed;

  entropy_collector u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .entropy_in(entropy_in), .osc_speed(osc_speed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fails = 0, cyc_tb = 0, t0 = 0;
  bit finished = 0, pat_on = 0;
  logic const_bit = 1'b0, rd_d = 1'b0;
  logic [31:0] cur_seed = '0, last_rd = '0;

  typedef struct { logic [31:0] exp; bit chk; string tag; } exp_t;
  exp_t sb_q[$];

  function automatic logic [31:0] pat_word(logic [31:0] seed, int w);
    return seed ^ (32'(w + 1) * 32'h9E37_79B9);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_tb <= cyc_tb + 1;
    rd_d   <= reg_rd;
  end

  // entropy source: bit k held over a whole four-cycle window
  always @(negedge clk) begin
    if (pat_on) begin
      automatic int n = cyc_tb - t0 + 1;
      automatic int k = (n - 1) / 4;
      if (n >= 1 && k < 256) entropy_in <= pat_word(cur_seed, k / 32)[31 - (k % 32)];
      else                   entropy_in <= 1'b0;
    end else begin
      entropy_in <= const_bit;
    end
  end

  // monitor: pops the expectation for each completed read
  always @(negedge clk) begin
    if (rd_d) begin
      automatic exp_t e = sb_q.pop_front();
      last_rd = reg_rdata;
      if (e.chk) check(e.tag, reg_rdata, e.exp);
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 t0 = cyc_tb;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, bit chk, string tag);
    exp_t e;
    e.exp = exp; e.chk = chk; e.tag = tag;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    sb_q.push_back(e);
    @(negedge clk);
    reg_rd = 1'b0;
    #1;
  endtask

  task automatic wait_done(output int elapsed);
    int tries = 0;
    do begin
      rd(A_CTL, 0, 0, "poll");
      tries++;
    end while (last_rd[0] && tries < 3000);
    elapsed = cyc_tb - t0;
  endtask

  task automatic check_words(string tag, logic [31:0] exp [8], int lo, int hi);
    for (int w = lo; w <= hi; w++) rd(A_D0 + AW'(4 * w), exp[w], 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] mem [8];
    int el;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 osc_speed after reset", 32'(osc_speed), 0);
    rd(A_CTL, 0, 1, "R1 ctl reset");
    rd(A_PER, 0, 1, "R1 period reset");
    for (int w = 0; w < 8; w++) rd(A_D0 + AW'(4 * w), 0, 1, "R1 data reset");

    // R11 period readback
    wr(A_PER, 32'h0000_03E8);
    rd(A_PER, 32'h3E8, 1, "R11 period readback");

    // R2 / R3 masked writes and field layout
    wr(A_CTL, 32'h000C_000C);
    rd(A_CTL, 32'h0C, 1, "R2 speed via mask");
    check("R3 osc_speed=3", 32'(osc_speed), 3);
    wr(A_CTL, 32'h0030_003F);
    rd(A_CTL, 32'h3C, 1, "R2 unmasked start/enable held");
    wr(A_CTL, 32'h0004_0000);
    rd(A_CTL, 32'h38, 1, "R2 single bit cleared");
    check("R3 osc_speed=2", 32'(osc_speed), 2);

    // R9 stop
    wr(A_CTL, 32'hFFFF_0000);
    rd(A_CTL, 0, 1, "R9 stop clears ctl");
    check("R9 osc_speed cleared", 32'(osc_speed), 0);

    // R5 / R6 / R7 full 256-bit collection, period 4
    wr(A_PER, 4);
    cur_seed = 32'hC0DE_1234; pat_on = 1;
    wr(A_CTL, 32'h003E_0036);
    wr(A_CTL, 32'h0001_0001);
    rd(A_CTL, 32'h37, 1, "R6 start held while running");
    wait_done(el);
    check("R7 256 bits x4 not early", 32'(el >= 1024), 1);
    check("R7 256 bits x4 not late", 32'(el <= 1040), 1);
    for (int w = 0; w < 8; w++) mem[w] = pat_word(cur_seed, w);
    check_words("R5 R6 256-bit words", mem, 0, 7);

    // R4 64-bit run keeps words 2..7
    cur_seed = 32'h5A5A_0F0F;
    wr(A_CTL, 32'h0030_0000);
    wr(A_CTL, 32'h0001_0001);
    wait_done(el);
    check("R7 64 bits x4 not early", 32'(el >= 256), 1);
    for (int w = 0; w < 2; w++) mem[w] = pat_word(cur_seed, w);
    check_words("R4 len 64", mem, 0, 7);

    // R4 192-bit run keeps words 6..7
    cur_seed = 32'h1357_9BDF;
    wr(A_CTL, 32'h0030_0020);
    wr(A_CTL, 32'h0001_0001);
    wait_done(el);
    for (int w = 0; w < 6; w++) mem[w] = pat_word(cur_seed, w);
    check_words("R4 len 192", mem, 0, 7);

    // R7 period 0 behaves as 1
    pat_on = 0; const_bit = 1'b1;
    wr(A_PER, 0);
    wr(A_CTL, 32'h0030_0000);
    wr(A_CTL, 32'h0001_0001);
    wait_done(el);
    check("R7 period 0 not early", 32'(el >= 64), 1);
    check("R7 period 0 one bit per cycle", 32'(el <= 80), 1);
    mem[0] = 32'hFFFF_FFFF; mem[1] = 32'hFFFF_FFFF;
    check_words("R7 period 0 data", mem, 0, 7);

    // R8 abort by clearing enable
    pat_on = 1; cur_seed = 32'hDEAD_BEEF;
    wr(A_PER, 4);
    wr(A_CTL, 32'h0030_0030);
    wr(A_CTL, 32'h0001_0001);
    repeat (100) @(posedge clk);
    wr(A_CTL, 32'h0002_0000);
    rd(A_CTL, 32'h34, 1, "R8 abort clears start");
    repeat (1100) @(posedge clk);
    check_words("R8 abort keeps results", mem, 0, 7);

    // R8 start without enable
    wr(A_CTL, 32'h0001_0001);
    repeat (4) @(posedge clk);
    rd(A_CTL, 32'h34, 1, "R8 start needs enable");
    repeat (1100) @(posedge clk);
    check_words("R8 no run without enable", mem, 0, 1);

    // R10 undefined offsets and read-only results
    rd(12'h408, 0, 1, "R10 undef 0x408");
    rd(12'h40C, 0, 1, "R10 undef 0x40C");
    rd(12'h430, 0, 1, "R10 undef 0x430");
    rd(12'h000, 0, 1, "R10 undef 0x000");
    wr(A_D0, 32'h1234_5678);
    wr(A_D0 + 12'h1C, 32'h1234_5678);
    rd(A_D0, mem[0], 1, "R10 result word 0 write ignored");
    rd(A_D0 + 12'h1C, mem[7], 1, "R10 result word 7 write ignored");

    // R9 final stop
    wr(A_CTL, 32'hFFFF_0000);
    rd(A_CTL, 0, 1, "R9 final stop");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule